// File: doc/BRIEF.md
# Mixed-Width Partitionable 64-Bit Adder

This block adds two 64-bit operands as a set of independent lanes. A two-bit lane-width command picks the base split: one 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. Every lane boundary is a cut. At a cut, the carry out of the lower lane is reported and is not passed into the next lane.

When the base split is 32-bit or 16-bit, a second control stage can subdivide one half of the word while the other half keeps the base width. The result is a word that holds lanes of mixed widths, for example one 32-bit lane next to four 8-bit lanes. A steering select picks the lower or upper half to receive the extra split. A grain select picks 16-bit or 8-bit pieces. A per-half enable decides whether that half accepts the extra split. The packed sums and the per-lane carries are registered, so results appear one clock after the operands are presented.

Top module: `msp_mixed_adder`

## Requirements
- R1: With `lw_mode`=00 the block performs one 64-bit addition. `lane_cout[7]` holds the carry out of bit 63 and `lane_cout[6:0]` are 0.
- R2: With `lw_mode`=10 the block performs two 32-bit additions. Bit 31 does not carry into bit 32.
- R3: With `lw_mode`=01 the block performs four 16-bit additions, cut after bits 15, 31 and 47.
- R4: With `lw_mode`=11 the block performs eight 8-bit additions, cut after every byte.
- R5: With `lw_mode` 00 or 11, the inputs `sub_fine`, `sub_upper`, `lo_split_en` and `hi_split_en` have no effect on `sum` or `lane_cout`.
- R6: With `lw_mode`=10 and `sub_fine`=0, the half chosen by the steering select (if enabled) becomes two 16-bit lanes.
- R7: With `lw_mode`=10 and `sub_fine`=1, the chosen half (if enabled) becomes four 8-bit lanes.
- R8: `sub_upper`=0 steers the extra split to bits 31:0 and `sub_upper`=1 steers it to bits 63:32. The half that is not chosen keeps the base lane width, even when its own enable is set.
- R9: The extra split applies to the chosen half only when that half's enable is 1: `lo_split_en` for the lower half, `hi_split_en` for the upper half.
- R10: With `lw_mode`=01, an enabled request splits the 16-bit lanes of the chosen half into 8-bit lanes, whatever the value of `sub_fine`.
- R11: `lane_cout[j]` equals the carry out of byte j (bits 8j+7..8j) when byte j ends a lane, and is 0 otherwise. Byte 7 always ends a lane.
- R12: `sum` and `lane_cout` are registered with one cycle of latency, and are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa | input | 64 | First operand, packed lanes |
| opb | input | 64 | Second operand, packed lanes |
| lw_mode | input | 2 | Base lane width: 00=64, 10=32, 01=16, 11=8 |
| sub_fine | input | 1 | Grain of the extra split in 32-bit mode: 0=16-bit, 1=8-bit |
| sub_upper | input | 1 | Half that receives the extra split: 0=lower, 1=upper |
| lo_split_en | input | 1 | Lower half accepts the extra split |
| hi_split_en | input | 1 | Upper half accepts the extra split |
| sum | output | 64 | Packed lane sums |
| lane_cout | output | 8 | Per-byte carry out, nonzero only at lane ends |

## Verification
Operands of all ones plus one make every byte produce a carry. This pattern exposes every cut at once: a missing cut shows up as a carry leaking into the next byte, and an extra cut shows up as a lost carry. Directed cases walk each base mode and each second-stage combination:
- steering to each half while the opposite half is enabled;
- a cleared enable on the chosen half;
- both grains in 32-bit and in 16-bit mode;
- all selects set in 64-bit and 8-bit modes.

Seeded random operands and controls then cover every mixed-width combination, including carries that arise only from particular bit patterns.

// File: rtl/msp_adder_pkg.sv
package msp_adder_pkg;
  localparam int LANE_W  = 8;
  localparam int N_LANES = 8;

  typedef enum logic [1:0] {
    LW_64 = 2'b00,
    LW_16 = 2'b01,
    LW_32 = 2'b10,
    LW_8  = 2'b11
  } lw_mode_e;
endpackage

// File: rtl/msp_cut_ctrl.sv
module msp_cut_ctrl
  import msp_adder_pkg::*;
#(
  parameter int N = N_LANES
) (
  input  logic [1:0]   lw_mode,
  input  logic         sub_fine,
  input  logic         sub_upper,
  input  logic         lo_split_en,
  input  logic         hi_split_en,
  output logic [N-2:0] cut
);
  localparam int HALF = N / 2;
  localparam int QTR  = N / 4;

  logic w16, w32, w8, st2_en, lo_side, hi_side;

  always_comb begin
    w8      = (lw_mode == LW_8);
    w16     = (lw_mode == LW_16);
    w32     = (lw_mode == LW_32);
    // second stage only when exactly one command bit is set
    st2_en  = lw_mode[0] ^ lw_mode[1];
    lo_side = st2_en & ~sub_upper & lo_split_en;
    hi_side = st2_en &  sub_upper & hi_split_en;
  end

  for (genvar k = 0; k < N - 1; k++) begin : g_bnd
    localparam int   G     = k + 1;
    localparam logic IN_LO = (G < HALF);
    localparam logic IN_HI = (G > HALF);
    localparam logic ON_Q  = ((G % QTR) == 0);
    localparam logic ON_H  = (G == HALF);
    logic first_cut, extra_cut;
    always_comb begin
      first_cut = w8 | (w16 & ON_Q) | (w32 & ON_H);
      extra_cut = ((IN_LO & lo_side) | (IN_HI & hi_side)) & (sub_fine | w16 | ON_Q);
      cut[k]    = first_cut | extra_cut;
    end
  end
endmodule

// File: rtl/msp_lane_slice.sv
module msp_lane_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] c;

  always_comb begin
    c[0] = cin;
    for (int i = 0; i < W; i++) begin
      s[i]   = a[i] ^ b[i] ^ c[i];
      c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end
    cout = c[W];
  end
endmodule

// File: rtl/msp_mixed_adder.sv
module msp_mixed_adder
  import msp_adder_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int N  = N_LANES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW*N-1:0] opa,
  input  logic [LW*N-1:0] opb,
  input  logic [1:0]      lw_mode,
  input  logic            sub_fine,
  input  logic            sub_upper,
  input  logic            lo_split_en,
  input  logic            hi_split_en,
  output logic [LW*N-1:0] sum,
  output logic [N-1:0]    lane_cout
);
  localparam int DW   = LW * N;
  localparam int HALF = N / 2;

  logic [N-2:0]  cut;
  logic [N-1:0]  co, ci;
  logic [DW-1:0] sum_nxt;
  logic [N-1:0]  cout_nxt;

  msp_cut_ctrl #(.N(N)) u_cut (
    .lw_mode     (lw_mode),
    .sub_fine    (sub_fine),
    .sub_upper   (sub_upper),
    .lo_split_en (lo_split_en),
    .hi_split_en (hi_split_en),
    .cut         (cut)
  );

  for (genvar j = 0; j < N; j++) begin : g_slice
    if (j == 0) begin : g_first
      assign ci[j] = 1'b0;
    end else begin : g_rest
      assign ci[j] = co[j-1] & ~cut[j-1];
    end

    msp_lane_slice #(.W(LW)) u_slice (
      .a    (opa[j*LW +: LW]),
      .b    (opb[j*LW +: LW]),
      .cin  (ci[j]),
      .s    (sum_nxt[j*LW +: LW]),
      .cout (co[j])
    );

    if (j == N - 1) begin : g_top
      assign cout_nxt[j] = co[j];
    end else begin : g_mid
      assign cout_nxt[j] = co[j] & cut[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum       <= '0;
      lane_cout <= '0;
    end else begin
      sum       <= sum_nxt;
      lane_cout <= cout_nxt;
    end
  end

  AST_FULL_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_mode == LW_64) |-> (cut == '0)); // R1
  AST_HALF_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_mode != LW_64) |-> cut[HALF-1]); // R2
  AST_BYTE_ALL_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_mode == LW_8) |-> (&cut)); // R4
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_mode == LW_32) |-> !((|cut[HALF-2:0]) && (|cut[N-2:HALF]))); // R8
  AST_WIDE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_mode == LW_64) |=> (sum == $past(opa + opb))); // R12
endmodule

// File: tb/sim_msp_mixed_adder.sv
module sim_msp_mixed_adder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] opa, opb;
  logic [1:0]  lw_mode;
  logic        sub_fine, sub_upper, lo_split_en, hi_split_en;
  logic [63:0] sum;
  logic [7:0]  lane_cout;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  msp_mixed_adder u0 (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .lw_mode(lw_mode),
    .sub_fine(sub_fine), .sub_upper(sub_upper), .lo_split_en(lo_split_en),
    .hi_split_en(hi_split_en), .sum(sum), .lane_cout(lane_cout)
  );

  // cut[k]: lane boundary between byte k and byte k+1
  function automatic logic [6:0] ref_cuts(logic [1:0] m, logic f, logic u, logic le, logic he);
    logic [6:0] c;
    logic lo, hi;
    case (m)
      2'b00:   c = 7'b0000000;
      2'b10:   c = 7'b0001000;
      2'b01:   c = 7'b0101010;
      default: c = 7'b1111111;
    endcase
    lo = !u && le;
    hi = u && he;
    if (m == 2'b10) begin
      if (lo) c |= f ? 7'b0000111 : 7'b0000010;
      if (hi) c |= f ? 7'b1110000 : 7'b0100000;
    end else if (m == 2'b01) begin
      if (lo) c |= 7'b0000101;
      if (hi) c |= 7'b1010000;
    end
    return c;
  endfunction

  function automatic logic [71:0] ref_add(logic [63:0] a, logic [63:0] b, logic [6:0] c);
    logic [63:0] s;
    logic [7:0]  co;
    logic        cy;
    logic [8:0]  t;
    cy = 1'b0;
    for (int j = 0; j < 8; j++) begin
      t = {1'b0, a[j*8 +: 8]} + {1'b0, b[j*8 +: 8]} + {8'd0, cy};
      s[j*8 +: 8] = t[7:0];
      if (j == 7 || c[j]) begin
        co[j] = t[8];
        cy = 1'b0;
      end else begin
        co[j] = 1'b0;
        cy = t[8];
      end
    end
    return {co, s};
  endfunction

  task automatic run(string tag, logic [63:0] a, logic [63:0] b, logic [1:0] m,
                     logic f, logic u, logic le, logic he);
    logic [71:0] exp;
    @(negedge clk);
    opa = a; opb = b; lw_mode = m;
    sub_fine = f; sub_upper = u; lo_split_en = le; hi_split_en = he;
    exp = ref_add(a, b, ref_cuts(m, f, u, le, he));
    @(negedge clk);
    checks++;
    if (sum !== exp[63:0]) begin
      errors++;
      $display("FAIL %s sum: actual %h expected %h", tag, sum, exp[63:0]);
    end
    checks++;
    if (lane_cout !== exp[71:64]) begin
      errors++;
      $display("FAIL %s R11 lane_cout: actual %b expected %b", tag, lane_cout, exp[71:64]);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] ones;
    logic [63:0] ra, rb;
    logic [3:0]  rs;
    void'($urandom(32'd1234));
    ones = 64'hFFFF_FFFF_FFFF_FFFF;
    rst_n = 1'b0;
    opa = ones; opb = 64'd1; lw_mode = 2'b00;
    sub_fine = 1'b0; sub_upper = 1'b0; lo_split_en = 1'b0; hi_split_en = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (sum !== 64'd0 || lane_cout !== 8'd0) begin
      errors++;
      $display("FAIL R12 reset: actual %h/%b expected 0/0", sum, lane_cout);
    end
    rst_n = 1'b1;

    run("R12 latency", 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'b00, 0, 0, 0, 0);
    run("R1 full width", ones, 64'd1, 2'b00, 0, 0, 0, 0);
    run("R2 two 32", ones, 64'h0000_0001_0000_0001, 2'b10, 0, 0, 0, 0);
    run("R3 four 16", ones, 64'h0001_0001_0001_0001, 2'b01, 0, 0, 0, 0);
    run("R4 eight 8", ones, 64'h0101_0101_0101_0101, 2'b11, 0, 0, 0, 0);
    run("R5 64 ignores selects", ones, 64'd1, 2'b00, 1, 0, 1, 1);
    run("R5 8 ignores selects", ones, 64'h0101_0101_0101_0101, 2'b11, 1, 1, 1, 1);
    run("R6 lower 16 split", ones, 64'h0101_0101_0101_0101, 2'b10, 0, 0, 1, 0);
    run("R7 lower 8 split", ones, 64'h0101_0101_0101_0101, 2'b10, 1, 0, 1, 0);
    run("R7 upper 8 split", ones, 64'h0101_0101_0101_0101, 2'b10, 1, 1, 0, 1);
    run("R8 upper steer lower enabled", ones, 64'h0101_0101_0101_0101, 2'b10, 0, 1, 1, 1);
    run("R8 lower steer upper enabled", ones, 64'h0101_0101_0101_0101, 2'b10, 1, 0, 1, 1);
    run("R9 lower enable clear", ones, 64'h0101_0101_0101_0101, 2'b10, 1, 0, 0, 1);
    run("R9 upper enable clear", ones, 64'h0101_0101_0101_0101, 2'b01, 0, 1, 1, 0);
    run("R10 16 lower fine0", ones, 64'h0101_0101_0101_0101, 2'b01, 0, 0, 1, 0);
    run("R10 16 upper fine1", ones, 64'h0101_0101_0101_0101, 2'b01, 1, 1, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rs = 4'($urandom);
      if (i % 4 == 0) rb = ~ra ^ {$urandom, $urandom} & 64'h0101_0101_0101_0101;
      run("R11 random", ra, rb, 2'($urandom), rs[0], rs[1], rs[2], rs[3]);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule